// File: doc/BRIEF.md
# Single-Flag ALU

This block is an 8-bit combinational arithmetic and logic unit whose only status output is one flag bit. The flag means something different for each operation: a carry or borrow for the arithmetic group, a zero or all-ones indicator for the logic group, and a condition for the flag-gated increment and decrement. The ALU takes a destination operand, a source operand, the current flag and a 4-bit operation code. It returns the new destination byte, the new flag and a write-enable that tells the register file whether the destination should be written.

A core uses it in the execute stage. The destination register goes to `d_i` and the source register goes to `r_i`. The flag register feeds `f_i` and is loaded from `f_o` every cycle. `res_o` is written back to the destination only while `we_o` is high. Multiply and memory access belong to other units.

Top module: `sf_alu`

## Requirements
- R1: With op code 0 (move), `res_o` equals `r_i`, `f_o` equals `f_i` and `we_o` is 1.
- R2: With op code 1 (xor), `res_o` is `d_i ^ r_i`, `we_o` is 1, and `f_o` is 1 exactly when the result is 0x00 or 0xFF.
- R3: With op code 2 (and), `res_o` is `d_i & r_i`, `we_o` is 1, and `f_o` is 1 exactly when the result is 0x00.
- R4: With op code 3 (or), `res_o` is `d_i | r_i`, `we_o` is 1, and `f_o` is 1 exactly when the result is 0xFF.
- R5: With op code 4 (add), `res_o` is the low byte of `d_i + r_i`, `f_o` is the carry out and `we_o` is 1. The incoming flag has no effect.
- R6: With op code 5 (add with flag), `res_o` is the low byte of `d_i + r_i + f_i`, `f_o` is the carry out and `we_o` is 1.
- R7: With op code 6 (subtract with flag), `res_o` is the low byte of `d_i - r_i - f_i`, `we_o` is 1, and `f_o` is 1 exactly when `r_i + f_i` exceeds `d_i`.
- R8: With op code 7 (not), `res_o` is `~d_i`, `f_o` is `~f_i` and `we_o` is 1.
- R9: With op code 8 (rotate right through flag), `res_o` is `{f_i, d_i[7:1]}`, `f_o` is `d_i[0]` and `we_o` is 1.
- R10: With op code 9 (flag-gated increment) and `f_i` = 1, `res_o` is `d_i + 1` and `f_o` is 1 only when `d_i` was 0xFF, and `we_o` is 1. With `f_i` = 0, `we_o` is 0, `res_o` equals `d_i` and `f_o` stays 0.
- R11: With op code 10 (flag-gated decrement) and `f_i` = 0, `res_o` is `d_i - 1` and `f_o` is 1 only when `d_i` was 0x00, and `we_o` is 1. With `f_i` = 1, `we_o` is 0, `res_o` equals `d_i` and `f_o` stays 1.
- R12: Op codes 11, 12 and 13 set the flag to 1, clear it to 0 and invert it. In all three cases `we_o` is 0 and `res_o` equals `d_i`.
- R13: Op codes 14 and 15 are no-ops: `we_o` is 0, `res_o` equals `d_i` and `f_o` equals `f_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| d_i | input | 8 | Destination operand |
| r_i | input | 8 | Source operand |
| f_i | input | 1 | Current flag |
| res_o | output | 8 | Result for the destination |
| f_o | output | 1 | Next flag value |
| we_o | output | 1 | Destination write-enable |

## Verification
The bench aims at the flag boundaries. In xor, the all-ones result must raise the flag just as the zero result does; a design that tested for zero only would leave the flag low on 0xFF. In add with flag and subtract with flag, the carry and borrow must appear when the incoming flag alone pushes the result past 0xFF or below zero. A unit that ignored the incoming flag would miss these, for example 0xFF+0x00+1 or 0x00−0x00−1. The gated increment and decrement are checked for both flag polarities and at 0xFF and 0x00, so a unit with an inverted gate condition, or one that asserted the write-enable when gated off, would show up. The bench also confirms that the rotate feeds the old flag into bit 7 rather than bit 0.

// File: rtl/sf_alu_pkg.sv
package sf_alu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MOVE  = 4'd0,
    OP_XOR   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_ADD   = 4'd4,
    OP_ADDF  = 4'd5,
    OP_SUBF  = 4'd6,
    OP_NOT   = 4'd7,
    OP_RR    = 4'd8,
    OP_INCF  = 4'd9,
    OP_DECF  = 4'd10,
    OP_SET   = 4'd11,
    OP_RESET = 4'd12,
    OP_FLIPF = 4'd13,
    OP_RSV0  = 4'd14,
    OP_RSV1  = 4'd15
  } sf_op_e;

  typedef enum logic [1:0] {
    UNIT_LOGIC = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_FLAG  = 2'd2
  } sf_unit_e;

  function automatic sf_unit_e unit_of(sf_op_e op);
    case (op)
      OP_MOVE, OP_XOR, OP_AND, OP_OR, OP_NOT:       unit_of = UNIT_LOGIC;
      OP_ADD, OP_ADDF, OP_SUBF, OP_INCF, OP_DECF:   unit_of = UNIT_ARITH;
      default:                                      unit_of = UNIT_FLAG;
    endcase
  endfunction
endpackage

// File: rtl/sf_logic_unit.sv
module sf_logic_unit
  import sf_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  sf_op_e         op_i,
  input  logic [W-1:0]   d_i,
  input  logic [W-1:0]   r_i,
  input  logic           f_i,
  output logic [W-1:0]   res_o,
  output logic           f_o,
  output logic           we_o
);
  logic [W-1:0] val;
  logic         all_zero;
  logic         all_one;

  always_comb begin
    case (op_i)
      OP_XOR:  val = d_i ^ r_i;
      OP_AND:  val = d_i & r_i;
      OP_OR:   val = d_i | r_i;
      OP_NOT:  val = ~d_i;
      default: val = r_i;
    endcase
  end

  assign all_zero = ~|val;
  assign all_one  = &val;

  always_comb begin
    we_o  = 1'b1;
    res_o = val;
    case (op_i)
      OP_XOR:  f_o = all_zero | all_one;
      OP_AND:  f_o = all_zero;
      OP_OR:   f_o = all_one;
      OP_NOT:  f_o = ~f_i;
      default: f_o = f_i;
    endcase
  end
endmodule

// File: rtl/sf_arith_unit.sv
module sf_arith_unit
  import sf_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  sf_op_e         op_i,
  input  logic [W-1:0]   d_i,
  input  logic [W-1:0]   r_i,
  input  logic           f_i,
  output logic [W-1:0]   res_o,
  output logic           f_o,
  output logic           we_o
);
  localparam int unsigned XW = W + 1;

  logic [XW-1:0] d_x;
  logic [XW-1:0] opnd_x;
  logic [XW-1:0] cin_x;
  logic [XW-1:0] sum_x;
  logic [XW-1:0] dif_x;
  logic          do_sub;
  logic          active;

  assign d_x = {1'b0, d_i};

  // second operand and carry/borrow in per operation
  always_comb begin
    opnd_x = {XW{1'b0}};
    cin_x  = {XW{1'b0}};
    do_sub = 1'b0;
    active = 1'b1;
    case (op_i)
      OP_ADD:  opnd_x = {1'b0, r_i};
      OP_ADDF: begin
        opnd_x = {1'b0, r_i};
        cin_x  = {{W{1'b0}}, f_i};
      end
      OP_SUBF: begin
        opnd_x = {1'b0, r_i};
        cin_x  = {{W{1'b0}}, f_i};
        do_sub = 1'b1;
      end
      OP_INCF: begin
        cin_x  = {{W{1'b0}}, 1'b1};
        active = f_i;
      end
      OP_DECF: begin
        cin_x  = {{W{1'b0}}, 1'b1};
        do_sub = 1'b1;
        active = ~f_i;
      end
      default: active = 1'b0;
    endcase
  end

  assign sum_x = d_x + opnd_x + cin_x;
  assign dif_x = d_x - opnd_x - cin_x;

  always_comb begin
    if (!active) begin
      res_o = d_i;
      f_o   = f_i;
      we_o  = 1'b0;
    end else if (do_sub) begin
      res_o = dif_x[W-1:0];
      f_o   = dif_x[W];
      we_o  = 1'b1;
    end else begin
      res_o = sum_x[W-1:0];
      f_o   = sum_x[W];
      we_o  = 1'b1;
    end
  end
endmodule

// File: rtl/sf_flag_unit.sv
module sf_flag_unit
  import sf_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  sf_op_e         op_i,
  input  logic [W-1:0]   d_i,
  input  logic           f_i,
  output logic [W-1:0]   res_o,
  output logic           f_o,
  output logic           we_o
);
  always_comb begin
    res_o = d_i;
    f_o   = f_i;
    we_o  = 1'b0;
    case (op_i)
      OP_RR: begin
        res_o = {f_i, d_i[W-1:1]};
        f_o   = d_i[0];
        we_o  = 1'b1;
      end
      OP_SET:   f_o = 1'b1;
      OP_RESET: f_o = 1'b0;
      OP_FLIPF: f_o = ~f_i;
      default:  ;
    endcase
  end
endmodule

// File: rtl/sf_alu.sv
module sf_alu
  import sf_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    d_i,
  input  logic [W-1:0]    r_i,
  input  logic            f_i,
  output logic [W-1:0]    res_o,
  output logic            f_o,
  output logic            we_o
);
  sf_op_e   op;
  sf_unit_e sel;

  logic [W-1:0] lg_res, ar_res, fl_res;
  logic         lg_f, ar_f, fl_f;
  logic         lg_we, ar_we, fl_we;

  assign op  = sf_op_e'(op_i);
  assign sel = unit_of(op);

  sf_logic_unit #(.W(W)) u_logic (
    .op_i(op), .d_i(d_i), .r_i(r_i), .f_i(f_i),
    .res_o(lg_res), .f_o(lg_f), .we_o(lg_we)
  );

  sf_arith_unit #(.W(W)) u_arith (
    .op_i(op), .d_i(d_i), .r_i(r_i), .f_i(f_i),
    .res_o(ar_res), .f_o(ar_f), .we_o(ar_we)
  );

  sf_flag_unit #(.W(W)) u_flag (
    .op_i(op), .d_i(d_i), .f_i(f_i),
    .res_o(fl_res), .f_o(fl_f), .we_o(fl_we)
  );

  always_comb begin
    case (sel)
      UNIT_LOGIC: begin
        res_o = lg_res; f_o = lg_f; we_o = lg_we;
      end
      UNIT_ARITH: begin
        res_o = ar_res; f_o = ar_f; we_o = ar_we;
      end
      default: begin
        res_o = fl_res; f_o = fl_f; we_o = fl_we;
      end
    endcase
  end
endmodule

// File: rtl/sf_alu_chk.sv
module sf_alu_chk
  import sf_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    d_i,
  input logic [W-1:0]    r_i,
  input logic            f_i,
  input logic [W-1:0]    res_o,
  input logic            f_o,
  input logic            we_o
);
  logic [W:0] wide_sum;
  assign wide_sum = {1'b0, d_i} + {1'b0, r_i};

  always_comb begin
    if (op_i == OP_MOVE) begin
      p_move_r1: assert (res_o == r_i && f_o == f_i && we_o)
        else $error("move mismatch");
    end
    if (op_i == OP_XOR) begin
      p_xor_flag_r2: assert (f_o == (res_o == '0 || res_o == '1))
        else $error("xor flag mismatch");
    end
    if (op_i == OP_AND) begin
      p_and_flag_r3: assert (f_o == (res_o == '0))
        else $error("and flag mismatch");
    end
    if (op_i == OP_OR) begin
      p_or_flag_r4: assert (f_o == (res_o == '1))
        else $error("or flag mismatch");
    end
    if (op_i == OP_ADD) begin
      p_add_carry_r5: assert ({f_o, res_o} == wide_sum)
        else $error("add mismatch");
    end
    if (op_i == OP_NOT) begin
      p_not_r8: assert (res_o == ~d_i && f_o != f_i && we_o)
        else $error("not mismatch");
    end
    if (op_i == OP_RR) begin
      p_rr_r9: assert (res_o[W-1] == f_i && f_o == d_i[0])
        else $error("rotate mismatch");
    end
    if (op_i == OP_INCF && !f_i) begin
      p_incf_gate_r10: assert (!we_o && res_o == d_i && !f_o)
        else $error("gated increment mismatch");
    end
    if (op_i == OP_DECF && f_i) begin
      p_decf_gate_r11: assert (!we_o && res_o == d_i && f_o)
        else $error("gated decrement mismatch");
    end
    if (op_i >= OP_SET) begin
      p_no_write_r12: assert (!we_o && res_o == d_i)
        else $error("flag command wrote destination");
    end
  end
endmodule

bind sf_alu sf_alu_chk #(.W(W)) u_chk (
  .op_i(op_i), .d_i(d_i), .r_i(r_i), .f_i(f_i),
  .res_o(res_o), .f_o(f_o), .we_o(we_o)
);

// File: tb/sim_sf_alu.sv
`timescale 1ns/1ps
module sim_sf_alu;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = 4'd15;
  logic [7:0] d_i = 8'h00;
  logic [7:0] r_i = 8'h00;
  logic       f_i = 1'b0;
  logic [7:0] res_o;
  logic       f_o;
  logic       we_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic       f;
    logic       we;
    int         op;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  sf_alu u0 (
    .op_i(op_i), .d_i(d_i), .r_i(r_i), .f_i(f_i),
    .res_o(res_o), .f_o(f_o), .we_o(we_o)
  );

  function automatic string tag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      8: return "R9";
      9: return "R10";
      10: return "R11";
      11, 12, 13: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic exp_t model(int op, int d, int r, int f);
    exp_t e;
    int t;
    e.op = op; e.res = d[7:0]; e.f = f[0]; e.we = 1'b0;
    case (op)
      0: begin e.res = r[7:0]; e.we = 1; end
      1: begin t = d ^ r; e.res = t[7:0]; e.f = (t == 0 || t == 255); e.we = 1; end
      2: begin t = d & r; e.res = t[7:0]; e.f = (t == 0); e.we = 1; end
      3: begin t = d | r; e.res = t[7:0]; e.f = (t == 255); e.we = 1; end
      4: begin t = d + r; e.res = t[7:0]; e.f = (t > 255); e.we = 1; end
      5: begin t = d + r + f; e.res = t[7:0]; e.f = (t > 255); e.we = 1; end
      6: begin t = d - r - f; e.res = t[7:0]; e.f = (t < 0); e.we = 1; end
      7: begin e.res = 8'(255 - d); e.f = (f == 0); e.we = 1; end
      8: begin t = f * 128 + d / 2; e.res = t[7:0]; e.f = (d % 2 == 1); e.we = 1; end
      9: if (f == 1) begin t = d + 1; e.res = t[7:0]; e.f = (t == 256); e.we = 1; end
      10: if (f == 0) begin t = d - 1; e.res = t[7:0]; e.f = (t == -1); e.we = 1; end
      11: e.f = 1;
      12: e.f = 0;
      13: e.f = (f == 0);
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(int op, int d, int r, int f);
    @(posedge clk);
    op_i <= op[3:0]; d_i <= d[7:0]; r_i <= r[7:0]; f_i <= f[0];
    sb_q.push_back(model(op, d, r, f));
  endtask

  // monitor: one expected item per cycle, compared mid-cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (res_o !== e.res || f_o !== e.f || we_o !== e.we) begin
        bad++;
        $display("FAIL %s op=%0d d=%h r=%h f=%b: got res=%h f=%b we=%b exp res=%h f=%b we=%b",
                 tag(e.op), e.op, d_i, r_i, f_i, res_o, f_o, we_o, e.res, e.f, e.we);
      end
    end
  end

  int pat [8] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h7F, 8'h3C};

  initial begin
    // reset-time check: reserved code, no write (R13)
    repeat (2) @(negedge clk);
    total++;
    if (we_o !== 1'b0 || res_o !== 8'h00 || f_o !== 1'b0) begin
      bad++;
      $display("FAIL R13 reset idle: got res=%h f=%b we=%b exp res=00 f=0 we=0", res_o, f_o, we_o);
    end
    rst_ni = 1'b1;

    // directed corners
    drive(1, 8'h0F, 8'hF0, 0);   // R2 xor all-ones raises flag
    drive(1, 8'h5A, 8'h5A, 0);   // R2 xor zero
    drive(1, 8'h12, 8'h34, 1);   // R2 flag cleared
    drive(2, 8'hF0, 8'h0F, 0);   // R3 and zero
    drive(3, 8'hF0, 8'h0F, 0);   // R4 or all-ones
    drive(4, 8'hFF, 8'h01, 1);   // R5 carry, flag ignored
    drive(5, 8'hFF, 8'h00, 1);   // R6 carry from flag alone
    drive(6, 8'h00, 8'h00, 1);   // R7 borrow from flag alone
    drive(6, 8'h05, 8'h05, 0);   // R7 no borrow
    drive(8, 8'h01, 8'h00, 1);   // R9 old flag into bit 7
    drive(9, 8'hFF, 8'h00, 1);   // R10 wrap with carry
    drive(9, 8'h10, 8'h00, 0);   // R10 gated off
    drive(10, 8'h00, 8'h00, 0);  // R11 borrow
    drive(10, 8'h10, 8'h00, 1);  // R11 gated off
    drive(0, 8'h11, 8'hC3, 1);   // R1 move
    drive(7, 8'hA5, 8'h00, 0);   // R8 not
    drive(11, 8'h42, 8'h00, 0);  // R12 set
    drive(12, 8'h42, 8'h00, 1);  // R12 reset
    drive(13, 8'h42, 8'h00, 1);  // R12 flip
    drive(14, 8'h99, 8'h11, 1);  // R13 reserved

    // sweep all op codes over the pattern set and both flag values
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int f = 0; f < 2; f++)
            drive(op, pat[i], pat[j], f);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule